// File: doc/BRIEF.md
# Explicit Prefetched Branch-Target Line Buffer

This block holds a small set of instruction lines that software fills ahead of time and later jumps into by number. A prefetch command ties a 24-bit instruction address to one of eight slots, each named by a 3-bit target ID, and starts a line read on a pipelined instruction-memory port. Each slot can have its own read outstanding, so up to eight reads may be in flight at once. A loop-entry command copies the fetch stage's next-line buffer straight into a slot, and that slot is usable at once.

A jump command names a slot and carries a condition computed elsewhere. If the condition holds and the slot is valid, the slot's address and 256-bit line go to the fetch stage on the next cycle. The line is copied out, so the same ID may be prefetched again at once. If the slot is still being fetched, the jump stalls. If the slot is empty or its read failed, a fault is raised instead. No path leads from the slots back to general registers.

Top module: `tgt_line_buf`

## Requirements
- R1: After reset every slot is absent, no memory request is presented, no redirect is given, and a taken jump to any slot raises `jmp_fault`.
- R2: A prefetch to slot `i` marks it fetching and presents a request carrying the prefetch address. The tag is 4 bits: bits [2:0] hold the slot ID and bit 3 holds the slot's sequence bit, which every prefetch or loop-entry to that slot inverts.
- R3: A taken jump to a fetching slot asserts `jmp_stall` in the same cycle, without `jmp_fault`, and gives no redirect on the next cycle.
- R4: A response whose tag matches a fetching slot and whose error flag is clear makes the slot valid. A taken jump to a valid slot sets `redir_valid` one cycle later, with that slot's address and line.
- R5: A matching response with the error flag set puts the slot in the fault state. A taken jump to it asserts `jmp_fault` and gives no redirect.
- R6: A jump whose condition is false produces no redirect, stall or fault, and leaves the slot's contents unchanged.
- R7: A response whose sequence bit differs from the slot's current one is discarded, so a slot that has been prefetched again keeps waiting for its newest read.
- R8: A loop-entry writes the given address and line into a slot and makes it valid on the next cycle, with no memory request.
- R9: While several slots wait to issue, the lowest-numbered one is presented first. A request is held while `mreq_ready` is low, and responses may return in any order.
- R10: When a prefetch targets the same slot as a taken jump in the same cycle, the redirect carries the slot's old address and line, and the slot is fetching afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pf_valid | input | 1 | Prefetch command |
| pf_id | input | 3 | Slot written by the prefetch |
| pf_addr | input | 24 | Instruction address to fetch |
| lp_valid | input | 1 | Loop-entry command |
| lp_id | input | 3 | Slot written by the loop entry |
| lp_addr | input | 24 | Address of the next-line buffer |
| lp_line | input | 256 | Contents of the next-line buffer |
| jmp_valid | input | 1 | Jump command |
| jmp_id | input | 3 | Slot selected by the jump |
| jmp_cond | input | 1 | Jump condition outcome |
| jmp_stall | output | 1 | Taken jump waits on a fetching slot |
| jmp_fault | output | 1 | Taken jump hit an absent or failed slot |
| redir_valid | output | 1 | Fetch stage switches to the line below |
| redir_addr | output | 24 | Address of the redirect line |
| redir_line | output | 256 | Redirect line contents |
| mreq_valid | output | 1 | Memory read request |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 24 | Read address |
| mreq_tag | output | 4 | Slot ID and sequence bit |
| mrsp_valid | input | 1 | Memory response |
| mrsp_tag | input | 4 | Tag returned with the response |
| mrsp_err | input | 1 | Response carries an error |
| mrsp_line | input | 256 | Returned line |

## Verification
The bench builds the block with its default parameters: eight slots, 24-bit addresses and 256-bit lines. With these values the 3-bit ID and the 4-bit tag match the encodings in the requirements exactly. The bench acts as the memory, so it controls when requests are accepted and in what order responses return. This lets it hold requests back, reply out of order, and send stale replies after a slot has been prefetched again.

// File: rtl/tgt_line_buf.sv
module tgt_line_buf #(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 24,
  parameter int LINE_W = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pf_valid,
  input  logic [$clog2(N_ENT)-1:0]      pf_id,
  input  logic [ADDR_W-1:0]             pf_addr,
  input  logic                          lp_valid,
  input  logic [$clog2(N_ENT)-1:0]      lp_id,
  input  logic [ADDR_W-1:0]             lp_addr,
  input  logic [LINE_W-1:0]             lp_line,
  input  logic                          jmp_valid,
  input  logic [$clog2(N_ENT)-1:0]      jmp_id,
  input  logic                          jmp_cond,
  output logic                          jmp_stall,
  output logic                          jmp_fault,
  output logic                          redir_valid,
  output logic [ADDR_W-1:0]             redir_addr,
  output logic [LINE_W-1:0]             redir_line,
  output logic                          mreq_valid,
  input  logic                          mreq_ready,
  output logic [ADDR_W-1:0]             mreq_addr,
  output logic [$clog2(N_ENT):0]        mreq_tag,
  input  logic                          mrsp_valid,
  input  logic [$clog2(N_ENT):0]        mrsp_tag,
  input  logic                          mrsp_err,
  input  logic [LINE_W-1:0]             mrsp_line
);
  localparam int IDW = $clog2(N_ENT);
  localparam logic [1:0] S_ABS = 2'd0, S_FET = 2'd1, S_FLT = 2'd2, S_VAL = 2'd3;

  logic [1:0]        st       [N_ENT];
  logic [ADDR_W-1:0] ent_addr [N_ENT];
  logic [LINE_W-1:0] ent_line [N_ENT];
  logic [N_ENT-1:0]  seq, pend;
  logic [IDW-1:0]    iss_id;

  always_comb begin
    iss_id = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (pend[i]) iss_id = IDW'(i);
  end

  assign mreq_valid = |pend;
  assign mreq_addr  = ent_addr[iss_id];
  assign mreq_tag   = {seq[iss_id], iss_id};

  generate
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      wire pf_hit  = pf_valid && pf_id == IDW'(g);
      wire lp_hit  = lp_valid && lp_id == IDW'(g) && !pf_hit;
      wire rsp_hit = mrsp_valid && mrsp_tag[IDW-1:0] == IDW'(g)
                     && mrsp_tag[IDW] == seq[g] && st[g] == S_FET;
      wire iss_hit = mreq_valid && mreq_ready && iss_id == IDW'(g);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st[g]   <= S_ABS;
          seq[g]  <= 1'b0;
          pend[g] <= 1'b0;
        end else if (pf_hit) begin
          st[g]   <= S_FET;
          seq[g]  <= ~seq[g];
          pend[g] <= 1'b1;
        end else if (lp_hit) begin
          st[g]   <= S_VAL;
          seq[g]  <= ~seq[g];
          pend[g] <= 1'b0;
        end else begin
          if (rsp_hit) st[g] <= mrsp_err ? S_FLT : S_VAL;
          if (iss_hit) pend[g] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (pf_hit) ent_addr[g] <= pf_addr;
        else if (lp_hit) begin
          ent_addr[g] <= lp_addr;
          ent_line[g] <= lp_line;
        end else if (rsp_hit && !mrsp_err) ent_line[g] <= mrsp_line;
      end
    end
  endgenerate

  wire       take    = jmp_valid && jmp_cond;
  wire [1:0] sel_st  = st[jmp_id];
  wire       jmp_hit = take && sel_st == S_VAL;

  assign jmp_stall = take && sel_st == S_FET;
  assign jmp_fault = take && (sel_st == S_ABS || sel_st == S_FLT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) redir_valid <= 1'b0;
    else        redir_valid <= jmp_hit;

  always_ff @(posedge clk)
    if (jmp_hit) begin
      redir_addr <= ent_addr[jmp_id];
      redir_line <= ent_line[jmp_id];
    end

  p_req_for_fetching_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> st[mreq_tag[IDW-1:0]] == S_FET);
  p_stall_blocks_redir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_stall |=> !redir_valid);
  p_stall_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(jmp_stall && jmp_fault));
  p_redir_needs_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(jmp_valid && jmp_cond));
  p_fault_blocks_redir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_fault |=> !redir_valid);
  p_false_cond_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_valid && !jmp_cond) |-> !jmp_stall && !jmp_fault);
endmodule

// File: tb/tgt_line_buf_tb_top.sv
module tgt_line_buf_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic pf_valid = 0, lp_valid = 0, jmp_valid = 0, jmp_cond = 0;
  logic [2:0] pf_id = 0, lp_id = 0, jmp_id = 0;
  logic [23:0] pf_addr = 0, lp_addr = 0;
  logic [255:0] lp_line = 0, mrsp_line = 0;
  logic mreq_ready = 0, mrsp_valid = 0, mrsp_err = 0;
  logic [3:0] mrsp_tag = 0;
  logic jmp_stall, jmp_fault, redir_valid, mreq_valid;
  logic [23:0] redir_addr, mreq_addr;
  logic [255:0] redir_line;
  logic [3:0] mreq_tag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tgt_line_buf dut_i (.*);

  task automatic chk(input bit ok, input string r, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [31:0] s);
    return {8{s}};
  endfunction

  task automatic prefetch(input logic [2:0] id, input logic [23:0] a);
    @(negedge clk); pf_valid = 1; pf_id = id; pf_addr = a;
    @(posedge clk); #1 pf_valid = 0;
  endtask

  task automatic take_req(input logic [23:0] a, input logic [2:0] id, input string r, output logic [3:0] tag);
    @(negedge clk); mreq_ready = 1; #1;
    chk(mreq_valid, r, mreq_valid, 1);
    chk(mreq_addr == a, r, mreq_addr, a);
    chk(mreq_tag[2:0] == id, r, mreq_tag[2:0], id);
    tag = mreq_tag;
    @(posedge clk); #1 mreq_ready = 0;
  endtask

  task automatic respond(input logic [3:0] tag, input bit err, input logic [255:0] l);
    @(negedge clk); mrsp_valid = 1; mrsp_tag = tag; mrsp_err = err; mrsp_line = l;
    @(posedge clk); #1 mrsp_valid = 0;
  endtask

  task automatic jump(input logic [2:0] id, input bit c, input bit e_st, input bit e_ft,
                      input bit e_rd, input logic [23:0] e_a, input logic [255:0] e_l, input string r);
    @(negedge clk); jmp_valid = 1; jmp_id = id; jmp_cond = c; #1;
    chk(jmp_stall == e_st, r, jmp_stall, e_st);
    chk(jmp_fault == e_ft, r, jmp_fault, e_ft);
    @(posedge clk); #1 jmp_valid = 0;
    @(negedge clk);
    chk(redir_valid == e_rd, r, redir_valid, e_rd);
    if (e_rd) begin
      chk(redir_addr == e_a, r, redir_addr, e_a);
      chk(redir_line == e_l, r, redir_line, e_l);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!mreq_valid, "R1 mreq", mreq_valid, 0);
    chk(!redir_valid, "R1 redir", redir_valid, 0);
    jump(3'd0, 1, 0, 1, 0, 0, 0, "R1 jump absent");
  endtask

  task automatic t_fetch_stall;
    prefetch(3'd4, 24'h123456);
    @(negedge clk); #1;
    chk(mreq_valid && mreq_addr == 24'h123456 && mreq_tag[2:0] == 3'd4, "R2 request",
        {mreq_valid, mreq_addr, mreq_tag}, {1'b1, 24'h123456, 1'b1, 3'd4});
    jump(3'd4, 1, 1, 0, 0, 0, 0, "R3 stall");
  endtask

  task automatic t_fill;
    logic [3:0] t;
    take_req(24'h123456, 3'd4, "R2 issue", t);
    respond(t, 0, mk(32'hA1A1_0004));
    jump(3'd4, 1, 0, 0, 1, 24'h123456, mk(32'hA1A1_0004), "R4 redirect");
  endtask

  task automatic t_cond_false;
    jump(3'd4, 0, 0, 0, 0, 0, 0, "R6 not taken");
    jump(3'd4, 1, 0, 0, 1, 24'h123456, mk(32'hA1A1_0004), "R6 unchanged");
  endtask

  task automatic t_err;
    logic [3:0] t;
    prefetch(3'd6, 24'h000666);
    take_req(24'h000666, 3'd6, "R5 issue", t);
    respond(t, 1, mk(32'hDEAD_BEEF));
    jump(3'd6, 1, 0, 1, 0, 0, 0, "R5 fault");
  endtask

  task automatic t_stale;
    logic [3:0] t1, t2;
    prefetch(3'd2, 24'h0A0A0A);
    take_req(24'h0A0A0A, 3'd2, "R7 first", t1);
    prefetch(3'd2, 24'h0B0B0B);
    take_req(24'h0B0B0B, 3'd2, "R7 second", t2);
    chk(t1[3] != t2[3], "R7 seq bit", t2, t1);
    respond(t1, 0, mk(32'h0000_000A));
    jump(3'd2, 1, 1, 0, 0, 0, 0, "R7 stale ignored");
    respond(t2, 0, mk(32'h0000_000B));
    jump(3'd2, 1, 0, 0, 1, 24'h0B0B0B, mk(32'h0000_000B), "R7 newest");
  endtask

  task automatic t_loop;
    @(negedge clk); lp_valid = 1; lp_id = 3'd0; lp_addr = 24'h00F00D; lp_line = mk(32'h1007_1007);
    @(posedge clk); #1 lp_valid = 0;
    @(negedge clk);
    chk(!mreq_valid, "R8 no request", mreq_valid, 0);
    jump(3'd0, 1, 0, 0, 1, 24'h00F00D, mk(32'h1007_1007), "R8 loop entry");
  endtask

  task automatic t_order;
    logic [3:0] t5, t1, t3;
    prefetch(3'd5, 24'h000505);
    prefetch(3'd1, 24'h000101);
    prefetch(3'd3, 24'h000303);
    @(negedge clk); #1;
    chk(mreq_valid && mreq_addr == 24'h000101, "R9 held lowest", mreq_addr, 24'h000101);
    take_req(24'h000101, 3'd1, "R9 first", t1);
    take_req(24'h000303, 3'd3, "R9 second", t3);
    take_req(24'h000505, 3'd5, "R9 third", t5);
    respond(t5, 0, mk(32'h5555_5555));
    respond(t1, 0, mk(32'h1111_1111));
    respond(t3, 0, mk(32'h3333_3333));
    jump(3'd5, 1, 0, 0, 1, 24'h000505, mk(32'h5555_5555), "R9 slot5");
    jump(3'd1, 1, 0, 0, 1, 24'h000101, mk(32'h1111_1111), "R9 slot1");
    jump(3'd3, 1, 0, 0, 1, 24'h000303, mk(32'h3333_3333), "R9 slot3");
  endtask

  task automatic t_reuse;
    @(negedge clk);
    jmp_valid = 1; jmp_id = 3'd4; jmp_cond = 1;
    pf_valid = 1; pf_id = 3'd4; pf_addr = 24'h444444;
    @(posedge clk); #1 jmp_valid = 0; pf_valid = 0;
    @(negedge clk);
    chk(redir_valid && redir_addr == 24'h123456, "R10 old addr", redir_addr, 24'h123456);
    chk(redir_line == mk(32'hA1A1_0004), "R10 old line", redir_line, mk(32'hA1A1_0004));
    jump(3'd4, 1, 1, 0, 0, 0, 0, "R10 refetching");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_fetch_stall();
    t_fill();
    t_cond_false();
    t_err();
    t_stale();
    t_loop();
    t_order();
    t_reuse();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule